// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the modem status byte of a 16550-style serial port. It watches four modem input lines: clear-to-send, data-set-ready, ring and carrier detect. Each line passes through a multi-flop synchronizer. The block stores the synchronized level of each line in the upper nibble and a sticky change flag for each line in the lower nibble. A host read returns the whole byte and then drops the change flags. The OR of those flags is driven out as the modem-status interrupt source.

For self-test, a loopback mode replaces the value the host sees. The status byte then shows four modem control outputs, and the change flags are neither shown nor cleared. Reading, loopback selection and the control bits come from the surrounding UART register file. Interrupt priority encoding is handled elsewhere.

Top module: `modem_status_reg`

## Requirements
- R1: Level bits sit at fixed positions in `status_o`: carrier detect bit 7, ring bit 6, data-set-ready bit 5, clear-to-send bit 4. The change flags for the same lines sit at bits 3, 2, 1 and 0 respectively.
- R2: When the synchronized level of clear-to-send, data-set-ready or carrier detect differs from the stored level, the stored level follows it and that line's change flag is set. The flag stays set until a clearing read.
- R3: The ring change flag (bit 2) is set only when the ring level goes from 1 to 0. A 0-to-1 ring transition updates bit 6 and leaves bit 2 unchanged.
- R4: With loopback off, `status_o` shows the complete register while `rd_en_i` is high. At the following clock edge bits 3..0 are cleared.
- R5: With `loop_en_i` high, `status_o` is {mcr_i[3], mcr_i[2], mcr_i[0], mcr_i[1], 4'b0000}. A read in this mode leaves every stored change flag unchanged.
- R6: After reset `status_o` reads 8'hB0, meaning carrier, data-set-ready and clear-to-send are at 1 and ring and all change flags are at 0. `any_delta_o` is 0.
- R7: `any_delta_o` is the OR of the four stored change flags.
- R8: If a line change reaches the register in the same cycle as a clearing read, the read shows the value from before the change. After that edge only the new change flag is set.
- R9: A change on a modem input first shows in `status_o` after exactly SYNC_STAGES+1 rising clock edges (3 by default). It is not visible after fewer edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| loop_en_i | input | 1 | Loopback select |
| mcr_i | input | 4 | Control bits: 3 OUT2, 2 OUT1, 1 RTS, 0 DTR |
| rd_en_i | input | 1 | Host read strobe for the status byte |
| status_o | output | 8 | Status byte seen by the host |
| any_delta_o | output | 1 | At least one change flag set |

## Verification
The hardest case to reach is a read strobe landing on the exact edge at which a synchronized change is committed (R8). The bench reaches it by counting edges from the negedge at which it toggles an input. It raises the read strobe after the second rising edge, so the read and the commit share the third. A change flag from an earlier transition is left pending first. This shows that the old flag is cleared while the new one survives. The same edge counting shows that the change is not visible one edge early (R9).

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES = 4;
  typedef logic [LINES-1:0] line_vec_t;

  // line index == bit position in each nibble of the status byte
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  // control bit positions used by loopback
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;

  localparam line_vec_t LVL_RST = line_vec_t'(4'b1011);
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msr_track.sv
module msr_track
  import msr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t sync_i,
  input  logic      clr_i,
  output line_vec_t lvl_o,
  output line_vec_t dlt_o
);
  line_vec_t lvl_q, dlt_q, set_dlt;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == IDX_RI) begin : g_trail
      // trailing edge only
      assign set_dlt[i] = lvl_q[i] & ~sync_i[i];
    end else begin : g_any
      assign set_dlt[i] = lvl_q[i] ^ sync_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_RST;
      dlt_q <= '0;
    end else begin
      lvl_q <= sync_i;
      dlt_q <= (clr_i ? '0 : dlt_q) | set_dlt;
    end
  end

  assign lvl_o = lvl_q;
  assign dlt_o = dlt_q;
endmodule

// File: rtl/msr_view.sv
module msr_view
  import msr_pkg::*;
(
  input  logic       loop_en_i,
  input  logic [3:0] mcr_i,
  input  line_vec_t  lvl_i,
  input  line_vec_t  dlt_i,
  output logic [7:0] status_o
);
  line_vec_t lb;

  always_comb begin
    lb          = '0;
    lb[IDX_CTS] = mcr_i[CTL_RTS];
    lb[IDX_DSR] = mcr_i[CTL_DTR];
    lb[IDX_RI]  = mcr_i[CTL_OUT1];
    lb[IDX_DCD] = mcr_i[CTL_OUT2];
  end

  assign status_o = loop_en_i ? {lb, 4'b0000} : {lvl_i, dlt_i};
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       loop_en_i,
  input  logic [3:0] mcr_i,
  input  logic       rd_en_i,
  output logic [7:0] status_o,
  output logic       any_delta_o
);
  line_vec_t raw_lvl, sync_lvl, lvl_w, dlt_w;
  logic      rd_clr;

  always_comb begin
    raw_lvl          = '0;
    raw_lvl[IDX_CTS] = cts_i;
    raw_lvl[IDX_DSR] = dsr_i;
    raw_lvl[IDX_RI]  = ri_i;
    raw_lvl[IDX_DCD] = dcd_i;
  end

  msr_sync #(.STAGES(SYNC_STAGES), .W(LINES), .RST_VAL(LVL_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lvl),
    .q_o   (sync_lvl)
  );

  // loopback reads leave the flags alone
  assign rd_clr = rd_en_i & ~loop_en_i;

  msr_track u_track (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_lvl),
    .clr_i (rd_clr),
    .lvl_o (lvl_w),
    .dlt_o (dlt_w)
  );

  msr_view u_view (
    .loop_en_i(loop_en_i),
    .mcr_i    (mcr_i),
    .lvl_i    (lvl_w),
    .dlt_i    (dlt_w),
    .status_o (status_o)
  );

  assign any_delta_o = |dlt_w;
endmodule

// File: rtl/modem_status_reg_chk.sv
module modem_status_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       loop_en_i,
  input logic       rd_en_i,
  input logic [7:0] status_o,
  input logic       any_delta_o,
  input logic [3:0] sync_lvl,
  input logic [3:0] lvl_w,
  input logic [3:0] dlt_w
);
  // R7
  any_delta_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |-> (any_delta_o == (|status_o[3:0])));

  // R4
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !loop_en_i && (sync_lvl == lvl_w)) |=> (dlt_w == 4'b0000));

  // R2
  change_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((sync_lvl ^ lvl_w) & 4'b1011) != 4'b0000)
    |=> ((dlt_w & $past((sync_lvl ^ lvl_w) & 4'b1011)) == $past((sync_lvl ^ lvl_w) & 4'b1011)));

  // R3
  ring_rise_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dlt_w[2] && !lvl_w[2] && sync_lvl[2]) |=> !dlt_w[2]);

  // R5
  loop_read_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_en_i && rd_en_i) |=> ((dlt_w & $past(dlt_w)) == $past(dlt_w)));

  // R5
  loop_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |-> (status_o[3:0] == 4'b0000));
endmodule

bind modem_status_reg modem_status_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .loop_en_i  (loop_en_i),
  .rd_en_i    (rd_en_i),
  .status_o   (status_o),
  .any_delta_o(any_delta_o),
  .sync_lvl   (sync_lvl),
  .lvl_w      (lvl_w),
  .dlt_w      (dlt_w)
);

// File: tb/modem_status_reg_bench.sv
`timescale 1ns/1ps
module modem_status_reg_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cts = 1'b1, dsr = 1'b1, ri = 1'b0, dcd = 1'b1;
  logic       loop_en = 1'b0;
  logic [3:0] mcr = 4'b0000;
  logic       rd_en = 1'b0;
  logic [7:0] status;
  logic       any_delta;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  modem_status_reg u_modem_status_reg (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cts_i      (cts),
    .dsr_i      (dsr),
    .ri_i       (ri),
    .dcd_i      (dcd),
    .loop_en_i  (loop_en),
    .mcr_i      (mcr),
    .rd_en_i    (rd_en),
    .status_o   (status),
    .any_delta_o(any_delta)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // default SYNC_STAGES=2: three edges from input change to status
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_read(input string req, input logic [7:0] exp_during);
    rd_en = 1'b1;
    check(req, status, exp_during);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R6 status", status, 8'hB0);
    check("R6 any_delta", {7'b0, any_delta}, 8'h00);
  endtask

  task automatic t_cts_change();
    cts = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 not yet visible", status, 8'hB0);
    @(posedge clk);
    @(negedge clk);
    check("R2/R1 cts delta", status, 8'hA1);
    check("R7 any_delta set", {7'b0, any_delta}, 8'h01);
  endtask

  task automatic t_read_clear();
    host_read("R4 read value", 8'hA1);
    check("R4 flags cleared", status, 8'hA0);
    check("R7 any_delta clear", {7'b0, any_delta}, 8'h00);
    host_read("R4 read quiet", 8'hA0);
    check("R4 quiet stays", status, 8'hA0);
  endtask

  task automatic t_ring();
    ri = 1'b1;
    settle();
    check("R3 ring rise no flag", status, 8'hE0);
    ri = 1'b0;
    settle();
    check("R3 ring fall flag", status, 8'hA4);
    host_read("R3 ring read", 8'hA4);
    check("R3 ring cleared", status, 8'hA0);
  endtask

  task automatic t_multi();
    dcd = 1'b0;
    dsr = 1'b0;
    settle();
    check("R2 dcd dsr flags", status, 8'h0A);
    cts = 1'b1;
    settle();
    check("R2 sticky flags", status, 8'h1B);
  endtask

  task automatic t_loop();
    loop_en = 1'b1;
    mcr = 4'b0101;
    @(negedge clk);
    check("R5 loop map a", status, 8'h60);
    mcr = 4'b1010;
    @(negedge clk);
    check("R5 loop map b", status, 8'h90);
    host_read("R5 loop read", 8'h90);
    loop_en = 1'b0;
    @(negedge clk);
    check("R5 flags kept", status, 8'h1B);
    check("R7 any after loop", {7'b0, any_delta}, 8'h01);
    host_read("R4 read after loop", 8'h1B);
    check("R4 cleared after loop", status, 8'h10);
  endtask

  task automatic t_same_cycle();
    dsr = 1'b1;
    settle();
    check("R2 dsr pending", status, 8'h32);
    cts = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_en = 1'b1;
    check("R8 read shows old", status, 8'h32);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 new flag survives", status, 8'h21);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cts_change();
    t_read_clear();
    t_ring();
    t_multi();
    t_loop();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule